// File: doc/BRIEF.md
# Codec Power-State Sequencer

This block steps a mixed-signal audio codec from reset to a working state. After reset is released and the power-down pin is high, it runs a fixed initialization period and, when requested, a self-calibration period. The converters then rest in power-down. From there they can be brought up through a timed exit period and later returned through a timed entry period. Every timed period runs to its end once begun. Only reset can cut one short.

While the sequence runs, the block reports two status flags (initializing and converters-down) and three activity codes: one each for the serial interface, the clock generators and the converters. It also decides, for each register address presented with a write request, whether the write is accepted or refused. The register file acts on that one-cycle verdict. Durations are cycle-count parameters, so a fast clock and a long millisecond delay need no extra logic.

Top module: `codec_pwr_seq`

## Requirements
- R1: While `rstN` is low, the block holds the all-down state with `initFlag`=1, `pdnoFlag`=1, `ifAct`=0, `clkAct`=0, `convAct`=0 and `rdAllowed`=0, and no write is accepted.
- R2: With `rstN` high and `pwrDnN` low, the block stays all-down. Once `pwrDnN` is high, the next clock edge starts initialization, with `initFlag`=1 for exactly INIT_CYC cycles and `clkAct`=0.
- R3: At the end of initialization, `acEn`=1 adds a calibration period of CAL_CYC cycles, with `initFlag`=0, `pdnoFlag`=1 and every write refused. `acEn`=0 goes straight to converter power-down.
- R4: In converter power-down (`initFlag`=0, `pdnoFlag`=1), the block stays put until `convPdReq`=0 and `pwrDnN`=1. It then spends EXIT_CYC cycles exiting and reaches powered-up, where `pdnoFlag`=0 and `convAct`=1.
- R5: In powered-up, `convPdReq`=1 or `pwrDnN`=0 starts an entry period of ENTER_CYC cycles with `pdnoFlag`=1, after which the block is back in converter power-down.
- R6: The timed periods (initialization, calibration, exit, entry) run to completion whatever `convPdReq`, `pwrDnN` or `acEn` do meanwhile.
- R7: Pulling `rstN` low aborts any state at once, without waiting for a clock edge, and returns the block to all-down.
- R8: In converter power-down, exit and entry, only addresses 16 through 24, 26 and 28 are writable. Any other address, including 27, is refused.
- R9: In powered-up every address is writable. In all-down, initialization and calibration every address is refused.
- R10: Each cycle with `wrReq`=1 gives exactly one of `wrAccept` or `wrReject` as a single-cycle pulse on the following cycle. Neither pulses without a request.
- R11: Activity codes are 0 = down, 1 = read-only, 2 = alive. During initialization `ifAct` is 1 for a slave interface (`isMaster`=0) and 0 for a master. After initialization, `ifAct`=2 and `clkAct`=1. `rdAllowed` is 1 exactly when `ifAct` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| pwrDnN | input | 1 | Active-low power-down pin |
| acEn | input | 1 | Request calibration after initialization |
| convPdReq | input | 1 | Converter power-down request |
| isMaster | input | 1 | Serial interface runs as master |
| wrReq | input | 1 | Register write request |
| wrAddr | input | ADDR_W | Register write address |
| wrAccept | output | 1 | Write accepted (one cycle after request) |
| wrReject | output | 1 | Write refused (one cycle after request) |
| rdAllowed | output | 1 | Register reads are served |
| initFlag | output | 1 | Initializing status flag |
| pdnoFlag | output | 1 | Converters-down status flag |
| ifAct | output | 2 | Interface activity code |
| clkAct | output | 2 | Clock generator activity code |
| convAct | output | 2 | Converter activity code |

## Verification
The hardest cases to reach are the calibration and entry periods. Their status flags and write rules match those of plain converter power-down, so they cannot be seen directly at the ports. The bench measures calibration by holding a write request to address 16 through the end of initialization and counting refusals until the first acceptance. It measures the entry period by clearing the power-down request one cycle after raising it, then timing how long `pdnoFlag` stays high: the result must equal the entry and exit lengths added together. A second exit run toggles the request and the pin midway, which shows that a running period cannot be interrupted.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

  typedef enum logic [2:0] {
    ST_ALL_DOWN,
    ST_INIT,
    ST_AUTOCAL,
    ST_CONV_PD,
    ST_EXITING,
    ST_POWERED,
    ST_ENTERING
  } seqState_e;

  typedef enum logic [1:0] {
    TM_INIT,
    TM_CAL,
    TM_EXIT,
    TM_ENTER
  } timerSel_e;

  typedef enum logic [1:0] {
    WR_NONE,
    WR_LIMITED,
    WR_ALL
  } wrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      timerLoad;
    timerSel_e timerSel;
    wrMode_e   wrMode;
  } seqCtl_t;

  localparam logic [1:0] ACT_DOWN     = 2'd0;
  localparam logic [1:0] ACT_READONLY = 2'd1;
  localparam logic [1:0] ACT_ALIVE    = 2'd2;

endpackage

// File: rtl/codec_seq_ctrl.sv
module codec_seq_ctrl
  import codec_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDnN,
  input  logic       acEn,
  input  logic       convPdReq,
  input  logic       isMaster,
  input  logic       timerDone,
  output seqCtl_t    ctl,
  output logic       initFlag,
  output logic       pdnoFlag,
  output logic [1:0] ifAct,
  output logic [1:0] clkAct,
  output logic [1:0] convAct
);

  seqState_e state, nextState;
  logic      loadNow;
  timerSel_e loadSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ALL_DOWN;
    else       state <= nextState;
  end

  // next state; a timer load accompanies every entry into a timed state
  always_comb begin
    nextState = state;
    loadNow   = 1'b0;
    loadSel   = TM_INIT;
    case (state)
      ST_ALL_DOWN: if (pwrDnN) begin
        nextState = ST_INIT;
        loadNow   = 1'b1;
        loadSel   = TM_INIT;
      end
      ST_INIT: if (timerDone) begin
        if (acEn) begin
          nextState = ST_AUTOCAL;
          loadNow   = 1'b1;
          loadSel   = TM_CAL;
        end else begin
          nextState = ST_CONV_PD;
        end
      end
      ST_AUTOCAL: if (timerDone) nextState = ST_CONV_PD;
      ST_CONV_PD: if (!convPdReq && pwrDnN) begin
        nextState = ST_EXITING;
        loadNow   = 1'b1;
        loadSel   = TM_EXIT;
      end
      ST_EXITING: if (timerDone) nextState = ST_POWERED;
      ST_POWERED: if (convPdReq || !pwrDnN) begin
        nextState = ST_ENTERING;
        loadNow   = 1'b1;
        loadSel   = TM_ENTER;
      end
      ST_ENTERING: if (timerDone) nextState = ST_CONV_PD;
      default: nextState = ST_ALL_DOWN;
    endcase
  end

  // per-state outputs
  always_comb begin
    ctl.timerLoad = loadNow;
    ctl.timerSel  = loadSel;
    ctl.wrMode    = WR_NONE;
    initFlag      = 1'b0;
    pdnoFlag      = 1'b1;
    ifAct         = ACT_ALIVE;
    clkAct        = ACT_READONLY;
    convAct       = ACT_DOWN;
    case (state)
      ST_ALL_DOWN: begin
        initFlag = 1'b1;
        ifAct    = rstN ? ACT_READONLY : ACT_DOWN;
        clkAct   = ACT_DOWN;
      end
      ST_INIT: begin
        initFlag = 1'b1;
        ifAct    = isMaster ? ACT_DOWN : ACT_READONLY;
        clkAct   = ACT_DOWN;
      end
      ST_AUTOCAL: ctl.wrMode = WR_NONE;
      ST_CONV_PD, ST_EXITING, ST_ENTERING: ctl.wrMode = WR_LIMITED;
      ST_POWERED: begin
        ctl.wrMode = WR_ALL;
        pdnoFlag   = 1'b0;
        convAct    = ACT_READONLY;
      end
      default: begin
        initFlag = 1'b1;
        ifAct    = ACT_DOWN;
        clkAct   = ACT_DOWN;
      end
    endcase
  end

endmodule

// File: rtl/codec_seq_dp.sv
module codec_seq_dp
  import codec_seq_pkg::*;
#(
  parameter int unsigned INIT_CYC  = 200000,
  parameter int unsigned CAL_CYC   = 1000000,
  parameter int unsigned EXIT_CYC  = 117500000,
  parameter int unsigned ENTER_CYC = 1250000,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned LIM_LO    = 16,
  parameter int unsigned LIM_HI    = 24,
  parameter int unsigned EXTRA_A   = 26,
  parameter int unsigned EXTRA_B   = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  output logic              timerDone,
  output logic              wrAccept,
  output logic              wrReject
);

  localparam int unsigned MAX_A   = (INIT_CYC > CAL_CYC) ? INIT_CYC : CAL_CYC;
  localparam int unsigned MAX_B   = (EXIT_CYC > ENTER_CYC) ? EXIT_CYC : ENTER_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam int unsigned NADDR   = 1 << ADDR_W;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    case (ctl.timerSel)
      TM_INIT:  loadVal = CNT_W'(INIT_CYC - 1);
      TM_CAL:   loadVal = CNT_W'(CAL_CYC - 1);
      TM_EXIT:  loadVal = CNT_W'(EXIT_CYC - 1);
      default:  loadVal = CNT_W'(ENTER_CYC - 1);
    endcase
  end

  // one shared down-counter; a timed state lasts loadVal+1 cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  count <= '0;
    else if (ctl.timerLoad)     count <= loadVal;
    else if (count != '0)       count <= count - 1'b1;
  end

  assign timerDone = (count == '0);

  // addresses writable while converters are not powered up
  logic [NADDR-1:0] limMask;
  for (genvar a = 0; a < NADDR; a++) begin : g_mask
    localparam bit IN_SET = (a >= LIM_LO && a <= LIM_HI) || a == EXTRA_A || a == EXTRA_B;
    assign limMask[a] = IN_SET;
  end

  logic permit;
  always_comb begin
    case (ctl.wrMode)
      WR_ALL:     permit = 1'b1;
      WR_LIMITED: permit = limMask[wrAddr];
      default:    permit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAccept <= 1'b0;
      wrReject <= 1'b0;
    end else begin
      wrAccept <= wrReq && permit;
      wrReject <= wrReq && !permit;
    end
  end

endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import codec_seq_pkg::*;
#(
  parameter int unsigned INIT_CYC  = 200000,
  parameter int unsigned CAL_CYC   = 1000000,
  parameter int unsigned EXIT_CYC  = 117500000,
  parameter int unsigned ENTER_CYC = 1250000,
  parameter int unsigned ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrDnN,
  input  logic              acEn,
  input  logic              convPdReq,
  input  logic              isMaster,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  output logic              wrAccept,
  output logic              wrReject,
  output logic              rdAllowed,
  output logic              initFlag,
  output logic              pdnoFlag,
  output logic [1:0]        ifAct,
  output logic [1:0]        clkAct,
  output logic [1:0]        convAct
);

  seqCtl_t ctl;
  logic    timerDone;

  codec_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pwrDnN    (pwrDnN),
    .acEn      (acEn),
    .convPdReq (convPdReq),
    .isMaster  (isMaster),
    .timerDone (timerDone),
    .ctl       (ctl),
    .initFlag  (initFlag),
    .pdnoFlag  (pdnoFlag),
    .ifAct     (ifAct),
    .clkAct    (clkAct),
    .convAct   (convAct)
  );

  codec_seq_dp #(
    .INIT_CYC  (INIT_CYC),
    .CAL_CYC   (CAL_CYC),
    .EXIT_CYC  (EXIT_CYC),
    .ENTER_CYC (ENTER_CYC),
    .ADDR_W    (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wrReq     (wrReq),
    .wrAddr    (wrAddr),
    .timerDone (timerDone),
    .wrAccept  (wrAccept),
    .wrReject  (wrReject)
  );

  assign rdAllowed = (ifAct != ACT_DOWN);

endmodule

// File: rtl/codec_pwr_seq_chk.sv
module codec_pwr_seq_chk #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrReq,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wrAccept,
  input logic              wrReject,
  input logic              initFlag,
  input logic              pdnoFlag,
  input logic [1:0]        clkAct,
  input logic [1:0]        convAct
);

  AST_WR_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> (wrAccept ^ wrReject)); // R10

  AST_WR_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !wrReq |=> !(wrAccept || wrReject)); // R10

  AST_NO_ADDR27_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && wrAddr == ADDR_W'(27) && pdnoFlag) |=> !wrAccept); // R8

  AST_CONV_ONLY_UP: assert property (@(posedge clk) disable iff (!rstN)
    (convAct != 2'd0) == !pdnoFlag); // R4

  AST_INIT_EXIT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(initFlag) |-> pdnoFlag); // R3

  AST_CLK_OFF_INIT: assert property (@(posedge clk) disable iff (!rstN)
    initFlag |-> (clkAct == 2'd0)); // R2

endmodule

bind codec_pwr_seq codec_pwr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrReq    (wrReq),
  .wrAddr   (wrAddr),
  .wrAccept (wrAccept),
  .wrReject (wrReject),
  .initFlag (initFlag),
  .pdnoFlag (pdnoFlag),
  .clkAct   (clkAct),
  .convAct  (convAct)
);

// File: tb/sim_codec_pwr_seq.sv
module sim_codec_pwr_seq;

  localparam int INIT_C  = 8;
  localparam int CAL_C   = 12;
  localparam int EXIT_C  = 20;
  localparam int ENTER_C = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrDnN = 1'b0;
  logic       acEn = 1'b0;
  logic       convPdReq = 1'b1;
  logic       isMaster = 1'b0;
  logic       wrReq = 1'b0;
  logic [4:0] wrAddr = '0;
  logic       wrAccept, wrReject, rdAllowed, initFlag, pdnoFlag;
  logic [1:0] ifAct, clkAct, convAct;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  codec_pwr_seq #(
    .INIT_CYC(INIT_C), .CAL_CYC(CAL_C), .EXIT_CYC(EXIT_C), .ENTER_CYC(ENTER_C), .ADDR_W(5)
  ) u0 (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .acEn(acEn), .convPdReq(convPdReq),
    .isMaster(isMaster), .wrReq(wrReq), .wrAddr(wrAddr), .wrAccept(wrAccept),
    .wrReject(wrReject), .rdAllowed(rdAllowed), .initFlag(initFlag), .pdnoFlag(pdnoFlag),
    .ifAct(ifAct), .clkAct(clkAct), .convAct(convAct)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // count negedges while pdnoFlag keeps the given level
  task automatic countPdno(input logic lvl, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (pdnoFlag != lvl || n > 5000) break;
      n++;
    end
  endtask

  // one write; verdict checked next cycle, then pulse must end
  task automatic doWrite(input int addr, input bit expOk, input string req);
    wrReq = 1'b1;
    wrAddr = 5'(addr);
    @(negedge clk);
    wrReq = 1'b0;
    check(req, $sformatf("accept addr %0d", addr), int'(wrAccept), int'(expOk));
    check(req, $sformatf("reject addr %0d", addr), int'(wrReject), int'(!expOk));
    @(negedge clk);
    check("R10", "pulse ends", int'(wrAccept | wrReject), 0);
  endtask

  // reset, release, measure initialization and calibration
  task automatic boot(input bit acV, input bit masterV, output int initLen, output int rejLen);
    bit first = 1'b1;
    rstN = 1'b0; pwrDnN = 1'b1; convPdReq = 1'b1; acEn = acV; isMaster = masterV;
    wrReq = 1'b1; wrAddr = 5'd16;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    initLen = 0;
    forever begin
      @(negedge clk);
      if (!initFlag || initLen > 5000) break;
      if (first) begin
        check("R11", "ifAct in init", int'(ifAct), masterV ? 0 : 1);
        check("R11", "rdAllowed in init", int'(rdAllowed), masterV ? 0 : 1);
        first = 1'b0;
      end
      initLen++;
    end
    rejLen = 0;
    while (wrReject && rejLen < 5000) begin
      rejLen++;
      @(negedge clk);
    end
    check("R3", "accepted after boot", int'(wrAccept), 1);
    wrReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic tReset();
    rstN = 1'b0; pwrDnN = 1'b1;
    wrReq = 1'b1; wrAddr = 5'd16;
    repeat (2) @(negedge clk);
    wrReq = 1'b0;
    check("R1", "initFlag", int'(initFlag), 1);
    check("R1", "pdnoFlag", int'(pdnoFlag), 1);
    check("R1", "ifAct", int'(ifAct), 0);
    check("R1", "clkAct", int'(clkAct), 0);
    check("R1", "convAct", int'(convAct), 0);
    check("R1", "rdAllowed", int'(rdAllowed), 0);
    check("R1", "no accept", int'(wrAccept), 0);
  endtask

  task automatic tPinHold();
    pwrDnN = 1'b0;
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    check("R2", "held all-down initFlag", int'(initFlag), 1);
    check("R2", "held all-down clkAct", int'(clkAct), 0);
    check("R11", "readable with pin low", int'(rdAllowed), 1);
    doWrite(20, 1'b0, "R9");
  endtask

  task automatic tBootNoCal();
    int iLen, rLen;
    boot(1'b0, 1'b0, iLen, rLen);
    check("R2", "init length", iLen, INIT_C);
    check("R3", "no calibration", rLen, 1);
    check("R4", "initFlag in conv pd", int'(initFlag), 0);
    check("R4", "pdnoFlag in conv pd", int'(pdnoFlag), 1);
    check("R11", "ifAct alive", int'(ifAct), 2);
    check("R11", "clkAct enableable", int'(clkAct), 1);
    doWrite(27, 1'b0, "R8");
    doWrite(16, 1'b1, "R8");
    doWrite(24, 1'b1, "R8");
    doWrite(25, 1'b0, "R8");
    doWrite(26, 1'b1, "R8");
    doWrite(28, 1'b1, "R8");
    doWrite(15, 1'b0, "R8");
    doWrite(0, 1'b0, "R8");
  endtask

  task automatic tBootCal();
    int iLen, rLen;
    boot(1'b1, 1'b1, iLen, rLen);
    check("R2", "init length master", iLen, INIT_C);
    check("R3", "calibration refusals", rLen, CAL_C + 1);
    check("R11", "readable after init", int'(rdAllowed), 1);
    isMaster = 1'b0;
  endtask

  task automatic tPowerUp();
    int n;
    pwrDnN = 1'b0; convPdReq = 1'b0;
    repeat (5) @(negedge clk);
    check("R4", "stays down with pin low", int'(pdnoFlag), 1);
    pwrDnN = 1'b1;
    countPdno(1'b1, n);
    check("R4", "exit length", n, EXIT_C);
    check("R4", "convAct up", int'(convAct), 1);
    repeat (8) @(negedge clk);
    check("R4", "powered holds", int'(pdnoFlag), 0);
    doWrite(27, 1'b1, "R9");
    doWrite(3, 1'b1, "R9");
  endtask

  task automatic tEnterByReq();
    int n;
    convPdReq = 1'b1;
    @(negedge clk);
    check("R5", "entering pdnoFlag", int'(pdnoFlag), 1);
    convPdReq = 1'b0;
    countPdno(1'b1, n);
    check("R6", "entry then exit length", n, ENTER_C + EXIT_C);
  endtask

  task automatic tEnterByPin();
    int n;
    pwrDnN = 1'b0;
    @(negedge clk);
    check("R5", "pin low leaves powered", int'(pdnoFlag), 1);
    repeat (25) @(negedge clk);
    check("R5", "rests in conv pd", int'(pdnoFlag), 1);
    doWrite(27, 1'b0, "R8");
    doWrite(18, 1'b1, "R8");
    pwrDnN = 1'b1;
    countPdno(1'b1, n);
    check("R4", "exit length again", n, EXIT_C);
  endtask

  task automatic tExitNoInterrupt();
    int n, m;
    convPdReq = 1'b1;
    countPdno(1'b0, n);
    repeat (ENTER_C + 2) @(negedge clk);
    convPdReq = 1'b0;
    repeat (3) @(negedge clk);
    convPdReq = 1'b1; pwrDnN = 1'b0;
    countPdno(1'b1, n);
    check("R6", "exit completes despite request", n + 3, EXIT_C);
    countPdno(1'b0, m);
    check("R5", "powered lasts one cycle", m + 1, 1);
    pwrDnN = 1'b1;
  endtask

  task automatic tResetAbort();
    int iLen, rLen;
    convPdReq = 1'b0;
    repeat (ENTER_C + 6) @(negedge clk);
    #1 rstN = 1'b0;
    #0.5;
    check("R7", "abort initFlag", int'(initFlag), 1);
    check("R7", "abort pdnoFlag", int'(pdnoFlag), 1);
    check("R7", "abort rdAllowed", int'(rdAllowed), 0);
    @(negedge clk);
    boot(1'b0, 1'b0, iLen, rLen);
    check("R7", "init after abort", iLen, INIT_C);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    tReset();
    tPinHold();
    tBootNoCal();
    tBootCal();
    tPowerUp();
    tEnterByReq();
    tEnterByPin();
    tExitNoInterrupt();
    tResetAbort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule